// File: doc/BRIEF.md
# Cycle Timer with Match Interrupt

This block keeps a free-running count of clock cycles and raises an interrupt when that count reaches a programmed value. Software uses a single register address for two things. A read at that address returns the live count, which is 32 or 64 bits wide. A write at the same address loads a 32-bit match value. The count itself cannot be loaded, and the match value cannot be read back.

The match compares only the low 32 bits of the count with the match value, whatever the counter width. A match sets a sticky pending flag. A separate acknowledge input clears the flag. The interrupt line is the pending flag gated by an enable bit, which software writes at a second address. A match value that is already behind the count does not fire until the low 32 bits wrap around. Each instance counts on its own clock and takes no synchronizing input.

Top module: `cyc_timer`

## Requirements
- R1: During and right after reset the count reads 0, the match value is all ones, the enable bit is 0, the pending flag is 0 and `irq` is low.
- R2: The count rises by exactly one on every clock edge out of reset. A read at address 0 returns the full count in the same cycle, with no extra latency.
- R3: A write at address 0 loads `wdata[31:0]` into the match value at the next edge. The count is not changed by the write, and address 0 never returns the match value.
- R4: When the low 32 bits of the count equal the match value, the pending flag is set at the following edge. This holds for a 64-bit count too, where the upper bits take no part in the match.
- R5: A match value that is behind the low 32 bits of the count produces no match until those bits wrap around.
- R6: The pending flag stays set until `ack` is high at an edge. If a match and `ack` fall on the same edge, the flag is set.
- R7: Loading a new match value does not clear a pending flag.
- R8: A write at address 1 loads the enable bit from `wdata[0]`. A read at address 1 returns the enable bit in bit 0 and the pending flag in bit 1, with all other bits 0. `irq` is high exactly when the pending flag and the enable bit are both 1. While the enable bit is 0 a match is still held as pending.
- R9: Addresses 2 and 3 read as 0. Writes to them change neither the match value nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (2) | Register address: 0 is count/match, 1 is control |
| we | input | 1 | Write strobe, sampled at the clock edge |
| wdata | input | CNT_W (64) | Write data |
| rdata | output | CNT_W (64) | Read data for the current `addr` |
| ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Interrupt request: pending flag gated by the enable bit |

## Verification
Match values a few cycles ahead of the count show that the interrupt fires on exactly one edge, at the right moment. A match value just behind the count shows that no false match occurs before a wrap. An acknowledge held across the match edge separates a design where setting wins from one where clearing wins. Reloading the match value while an interrupt is pending, and matching while the enable bit is off, show that the flag is sticky and that the enable only gates the output. Random mixes of reads at every address, stray writes to unused addresses, enable toggles and pulses of `ack` are checked against a bench model, cycle by cycle.

// File: rtl/cyct_pkg.sv
package cyct_pkg;
  localparam int CMP_W = 32;
  typedef logic [CMP_W-1:0] cmp_t;

  // low-half equality used for the match event
  function automatic logic low_match(input cmp_t cnt_low, input cmp_t cmp);
    return cnt_low == cmp;
  endfunction

  // next value of the sticky pending flag: a new match beats acknowledge
  function automatic logic pend_next(input logic pend, input logic hit, input logic ack);
    if (hit) return 1'b1;
    if (ack) return 1'b0;
    return pend;
  endfunction

  // control readback layout: bit0 enable, bit1 pending
  function automatic logic [1:0] ctrl_word(input logic en, input logic pend);
    return {pend, en};
  endfunction
endpackage

// File: rtl/cyct_counter.sv
module cyct_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  localparam int LO_W = cyct_pkg::CMP_W;

  generate
    if (CNT_W > LO_W) begin : g_split
      localparam int HI_W = CNT_W - LO_W;
      logic [LO_W-1:0] lo_q;
      logic [HI_W-1:0] hi_q;
      logic            lo_carry;

      assign lo_carry = &lo_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
        end else begin
          lo_q <= lo_q + 1'b1;
          if (lo_carry) hi_q <= hi_q + 1'b1;
        end
      end
      assign count = {hi_q, lo_q};
    end else begin : g_flat
      logic [CNT_W-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_q + 1'b1;
      end
      assign count = c_q;
    end
  endgenerate
endmodule

// File: rtl/cyct_compare.sv
module cyct_compare
  import cyct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  cmp_t load_val,
  input  cmp_t cnt_low,
  output cmp_t cmp,
  output logic hit
);
  cmp_t cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cmp_q <= '1;
    else if (load) cmp_q <= load_val;
  end

  assign cmp = cmp_q;
  assign hit = low_match(cnt_low, cmp_q);
endmodule

// File: rtl/cyct_irq.sv
module cyct_irq
  import cyct_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic ack,
  input  logic en_load,
  input  logic en_val,
  output logic pending,
  output logic enable,
  output logic irq
);
  logic pend_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_next(pend_q, hit, ack);
      if (en_load) en_q <= en_val;
    end
  end

  assign pending = pend_q;
  assign enable  = en_q;
  assign irq     = pend_q & en_q;
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer #(
  parameter int CNT_W      = 64,
  parameter int ADDR_W     = 2,
  parameter int TIMER_ADDR = 0,
  parameter int CTRL_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  input  logic              ack,
  output logic              irq
);
  import cyct_pkg::*;

  localparam int CTRL_W = 2;

  logic [CNT_W-1:0] cnt;
  cmp_t             cnt_low;
  cmp_t             cmp;
  logic             hit;
  logic             pending;
  logic             enable;
  logic             sel_timer, sel_ctrl;
  logic             wr_cmp, wr_ctrl;

  assign sel_timer = (addr == ADDR_W'(TIMER_ADDR));
  assign sel_ctrl  = (addr == ADDR_W'(CTRL_ADDR));
  assign wr_cmp    = we & sel_timer;
  assign wr_ctrl   = we & sel_ctrl;
  assign cnt_low   = cnt[CMP_W-1:0];

  cyct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cnt)
  );

  cyct_compare u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_cmp),
    .load_val (wdata[CMP_W-1:0]),
    .cnt_low  (cnt_low),
    .cmp      (cmp),
    .hit      (hit)
  );

  cyct_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .ack     (ack),
    .en_load (wr_ctrl),
    .en_val  (wdata[0]),
    .pending (pending),
    .enable  (enable),
    .irq     (irq)
  );

  logic [CNT_W-1:0] ctrl_ext;
  generate
    if (CNT_W > CTRL_W) begin : g_ext
      assign ctrl_ext = {{(CNT_W-CTRL_W){1'b0}}, ctrl_word(enable, pending)};
    end else begin : g_noext
      assign ctrl_ext = ctrl_word(enable, pending);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (sel_timer)     rdata = cnt;
    else if (sel_ctrl) rdata = ctrl_ext;
  end
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
  parameter int CNT_W      = 64,
  parameter int ADDR_W     = 2,
  parameter int TIMER_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic [CNT_W-1:0]  wdata,
  input logic              ack,
  input logic [CNT_W-1:0]  cnt,
  input logic [31:0]       cmp,
  input logic              hit,
  input logic              pending
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> cnt == $past(cnt) + 1'b1);

  assert_cmp_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_W'(TIMER_ADDR)) |=> cmp == $past(wdata[31:0]));

  assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == ADDR_W'(TIMER_ADDR)) |=> $stable(cmp));

  assert_match_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pending);

  assert_rise_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(hit));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !hit) |=> !pending);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
endmodule

bind cyc_timer cyc_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .TIMER_ADDR(TIMER_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .ack(ack),
  .cnt(cnt), .cmp(cmp), .hit(hit), .pending(pending)
);

// File: tb/cyc_timer_test.sv
module cyc_timer_test;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [CNT_W-1:0]  wdata = '0;
  logic [CNT_W-1:0]  rdata;
  logic              ack = 1'b0;
  logic              irq;

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  cyc_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .ack(ack), .irq(irq)
  );

  // bench model built from the requirements
  logic [CNT_W-1:0] m_cnt;
  logic [31:0]      m_cmp;
  logic             m_en, m_pend;

  function automatic logic model_pend(input logic p, input logic [31:0] lo,
                                      input logic [31:0] c, input logic a);
    logic matched;
    matched = (lo == c);
    return matched ? 1'b1 : (a ? 1'b0 : p);
  endfunction

  function automatic logic [CNT_W-1:0] model_read(input logic [ADDR_W-1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return CNT_W'({m_pend, m_en});
      default: return '0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_cmp <= '1; m_en <= 1'b0; m_pend <= 1'b0;
    end else begin
      m_cnt  <= m_cnt + 1'b1;
      if (we && addr == 2'd0) m_cmp <= wdata[31:0];
      if (we && addr == 2'd1) m_en  <= wdata[0];
      m_pend <= model_pend(m_pend, m_cnt[31:0], m_cmp, ack);
    end
  end

  task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    string tag;
    @(posedge clk);
    #3;
    tag = (addr == 2'd0) ? "R2 count read" : (addr == 2'd1) ? "R8 ctrl read" : "R9 unused read";
    chk(tag, rdata, model_read(addr));
    chk("R8 irq gating", CNT_W'(irq), CNT_W'(m_pend & m_en));
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] v);
    addr = a; we = 1'b1; wdata = v;
    step();
    we = 1'b0; addr = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int rises;
    logic prev;
    // R1: state held by reset
    #2;
    chk("R1 count at reset", rdata, '0);
    chk("R1 irq at reset", CNT_W'(irq), '0);
    addr = 2'd1; #1;
    chk("R1 ctrl at reset", rdata, '0);
    addr = 2'd0;
    #9 rst_n = 1'b1;

    // R2: free counting
    for (int i = 0; i < 6; i++) step();

    // R4: match a few cycles ahead, enable on
    wr(2'd1, 1);
    wr(2'd0, CNT_W'(m_cnt[31:0] + 32'd6));
    rises = 0; prev = irq;
    for (int i = 0; i < 12; i++) begin
      step();
      if (irq && !prev) rises++;
      prev = irq;
    end
    chk("R4 single match", rises, 1);
    chk("R4 pending after match", CNT_W'(irq), 1);

    // R7: reload while pending
    wr(2'd0, CNT_W'(m_cnt[31:0] + 32'd1000));
    step();
    chk("R7 pending kept over reload", CNT_W'(irq), 1);

    // R3: match value not readable at address 0
    chk("R3 address 0 returns count", rdata, m_cnt);

    // R6: acknowledge clears, then set beats ack
    ack = 1'b1; step(); ack = 1'b0;
    chk("R6 ack clears", CNT_W'(irq), 0);
    wr(2'd0, CNT_W'(m_cnt[31:0] + 32'd5));
    ack = 1'b1;
    rises = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (irq) rises++;
    end
    ack = 1'b0;
    chk("R6 match wins over ack", rises, 1);

    // R5: match value already behind
    wr(2'd0, CNT_W'(m_cnt[31:0] - 32'd3));
    rises = 0;
    for (int i = 0; i < 300; i++) begin
      step();
      if (irq) rises++;
    end
    chk("R5 no match behind count", rises, 0);

    // R8: masked match still pending
    wr(2'd1, 0);
    wr(2'd0, CNT_W'(m_cnt[31:0] + 32'd4));
    for (int i = 0; i < 8; i++) step();
    chk("R8 masked irq low", CNT_W'(irq), 0);
    addr = 2'd1; step();
    chk("R8 pending visible while masked", rdata, CNT_W'(2'b10));
    wr(2'd1, 1);
    chk("R8 enable exposes pending", CNT_W'(irq), 1);

    // R9: writes to unused addresses are ignored
    ack = 1'b1; step(); ack = 1'b0;
    wr(2'd2, CNT_W'(m_cnt[31:0] + 32'd4));
    wr(2'd3, 0);
    for (int i = 0; i < 8; i++) step();
    chk("R9 unused write made no match", CNT_W'(irq), 0);
    addr = 2'd1; step();
    chk("R9 enable untouched", rdata, CNT_W'(2'b01));
    addr = 2'd3; step();
    chk("R9 unused reads zero", rdata, '0);

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      ack = ($urandom_range(0, 9) == 0);
      addr = ADDR_W'($urandom_range(0, 3));
      we = 1'b0;
      if (r < 12) begin
        addr = 2'd0; we = 1'b1;
        wdata = {$urandom, 32'(m_cnt[31:0] + $urandom_range(1, 40))};
      end else if (r < 18) begin
        addr = 2'd1; we = 1'b1; wdata = CNT_W'($urandom);
      end else if (r < 22) begin
        we = 1'b1; addr = ADDR_W'($urandom_range(2, 3)); wdata = {$urandom, $urandom};
      end
      step();
    end
    we = 1'b0; ack = 1'b0;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule